// File: doc/BRIEF.md
# Floating-Point Identification Register Access Gate

This block decides the fate of one read or write of the floating-point identification register. A request carries the current exception level and a snapshot of the control state around it: whether EL2 and EL3 exist, their 32-bit or 64-bit execution state, host mode, the non-secure flag, the coprocessor-10 enables, the FP trap bits, the host FP enable bit, the hypervisor coprocessor trap, the ID-group trap and two secure-debug qualifiers. One clock later the block reports exactly one outcome. The outcome is one of: completion, undefined instruction, a trap to 64-bit EL2, a trap to 64-bit EL3, or a hypervisor trap taken in 32-bit state. Each trap comes with a syndrome code.

The checks form a priority chain, and the chain depends on the privilege level. A completed read returns a 32-bit identification word built from parameters. A write that completes has no effect, because the register cannot be written. The block does not perform exception entry and does not write any syndrome register. The integrating pipeline does both from the outcome and the code.

Top module: `fpid_access_gate`

## Requirements
- R1: A request sampled with `req_valid` high at a rising edge produces `rsp_valid` high for exactly the following cycle. A cycle with no request produces no response, and all outputs are 0 in reset.
- R2: While `rsp_valid` is high, exactly one of `rsp_done`, `rsp_undef`, `rsp_trap_el2`, `rsp_trap_el3` and `rsp_trap_hyp` is high. While `rsp_valid` is low, all five are low, and so are `rsp_code` and `rsp_rdata`.
- R3: Any request with `req_el` = 0 gives undefined instruction.
- R4: At EL1 and EL2, the first check is the early secure-debug check. If EL3 is present and 64-bit, `el3_fp_trap` = 1 and `dbg_undef_early` = 1, the result is undefined instruction, and no later check is considered.
- R5: At EL1, the second check gives undefined instruction in either of two cases: `cp10_access` = 2'b00, or EL3 is present and 32-bit with `ns_flag` = 1 and `ns_cp10_en` = 0.
- R6: The host FP check gives a trap to EL2 with code 0x07 when EL2 is enabled, 64-bit and in host mode (`el2_host` = 1) and `host_fp_en_lo` = 0. At EL1 only, the same trap with code 0x07 is also given, and checked before the host FP check, when EL2 is enabled, 64-bit, not in host mode and `el2_fp_trap` = 1.
- R7: The hypervisor trap is given when EL2 is enabled and 32-bit, and either the R5 non-secure condition holds or `hyp_cp10_trap` = 1. Its code is 0x08 for a request from EL1 and 0x00 for a request from EL2. This check comes after those of R6.
- R8: At EL1 only, and after R7, `id_trap` = 1 with EL2 enabled gives a trap to EL2 with code 0x08 if EL2 is 64-bit, and a hypervisor trap with code 0x08 if EL2 is 32-bit.
- R9: The last check at EL1 and EL2 applies when EL3 is present and 64-bit with `el3_fp_trap` = 1. The result is undefined instruction if `dbg_undef_late` = 1, and otherwise a trap to EL3 with code 0x07.
- R10: At EL3 the only failure is `cp10_access` = 2'b00, which gives undefined instruction. Otherwise the request completes. A request at EL3 never traps.
- R11: A completed read returns {IMPLEMENTER[31:24], 1'b0 at bit 23, SUBARCH[22:16], PART[15:8], VARIANT[7:4], REVISION[3:0]}. Every other response carries `rsp_rdata` = 0, and a trap-free response carries `rsp_code` = 0.
- R12: A write that passes every check completes with `rsp_rdata` = 0 and changes nothing. A later read returns the same word as before.
- R13: The SUBARCH parameter is restricted to 7'h03 or 7'h04. Any other value is rejected at elaboration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_el | input | 2 | Current exception level |
| el2_enabled | input | 1 | EL2 enabled in the current security state |
| el2_is_64 | input | 1 | EL2 runs in 64-bit state |
| el2_host | input | 1 | EL2 host mode selected |
| el3_present | input | 1 | EL3 implemented |
| el3_is_64 | input | 1 | EL3 runs in 64-bit state |
| ns_flag | input | 1 | Non-secure state flag of a 32-bit EL3 |
| ns_cp10_en | input | 1 | Non-secure coprocessor-10 enable |
| cp10_access | input | 2 | Coprocessor-10 access field, 00 = no access |
| el2_fp_trap | input | 1 | FP trap bit of a 64-bit EL2 |
| el3_fp_trap | input | 1 | FP trap bit of a 64-bit EL3 |
| host_fp_en_lo | input | 1 | Low bit of the host-mode FP enable field |
| hyp_cp10_trap | input | 1 | Hypervisor coprocessor-10 trap bit |
| id_trap | input | 1 | ID-group trap bit of EL2 |
| dbg_undef_early | input | 1 | Secure-debug undefined takes priority |
| dbg_undef_late | input | 1 | Secure-debug undefined for the final EL3 check |
| rsp_valid | output | 1 | Response valid, one cycle per request |
| rsp_done | output | 1 | Access completes |
| rsp_undef | output | 1 | Undefined instruction |
| rsp_trap_el2 | output | 1 | Trap to 64-bit EL2 |
| rsp_trap_el3 | output | 1 | Trap to 64-bit EL3 |
| rsp_trap_hyp | output | 1 | Hypervisor trap in 32-bit state |
| rsp_code | output | 6 | Syndrome code of a trap |
| rsp_rdata | output | 32 | Read data of a completed read |

## Verification
Some rules hold on every cycle, and the assertions check them there. These are the one-cycle response timing, the single outcome per response, silence between responses, undefined instruction at EL0, the absence of traps at EL3, the zero read data on writes and failed reads, and the link between the hypervisor trap code and the requesting level. The priority order cannot be seen one cycle at a time. This covers the early secure-debug check winning over every other cause, the EL1-only checks, and the host FP case outranking the hypervisor trap. The bench shows these by sweeping every combination of level and control bits and comparing each response with a model written in the bench. Only directed scenarios can show the exact read word layout and that a completed write leaves later reads unchanged.

// File: rtl/fpid_pkg.sv
package fpid_pkg;
  localparam int CODE_W = 6;
  localparam int WORD_W = 32;

  typedef enum logic [2:0] {
    OUT_DONE  = 3'd0,
    OUT_UNDEF = 3'd1,
    OUT_TRAP2 = 3'd2,
    OUT_TRAP3 = 3'd3,
    OUT_HYP   = 3'd4
  } fpid_outcome_e;

  localparam logic [CODE_W-1:0] CODE_FP_USE = 6'h07;
  localparam logic [CODE_W-1:0] CODE_ID_GRP = 6'h08;
  localparam logic [CODE_W-1:0] CODE_HYP_L2 = 6'h00;

  function automatic logic [WORD_W-1:0] pack_id_word(
    input logic [7:0] impl, input logic [6:0] sub,
    input logic [7:0] part, input logic [3:0] variant, input logic [3:0] rev);
    return {impl, 1'b0, sub, part, variant, rev};
  endfunction

  function automatic logic subarch_ok(input logic [6:0] sub);
    return (sub == 7'h03) || (sub == 7'h04);
  endfunction
endpackage

// File: rtl/fpid_id_word.sv
module fpid_id_word
  import fpid_pkg::*;
#(
  parameter logic [7:0] IMPLEMENTER = 8'h5A,
  parameter logic [6:0] SUBARCH     = 7'h03,
  parameter logic [7:0] PART        = 8'h30,
  parameter logic [3:0] VARIANT     = 4'h1,
  parameter logic [3:0] REVISION    = 4'h2
) (
  output logic [WORD_W-1:0] id_word
);
  // Only the two hardware-complete subarchitectures are legal
  if (!subarch_ok(SUBARCH)) begin : g_bad_subarch
    $error("assert_subarch_legal_R13: SUBARCH %0h not allowed", SUBARCH);
  end

  assign id_word = pack_id_word(IMPLEMENTER, SUBARCH, PART, VARIANT, REVISION);
endmodule

// File: rtl/fpid_rule_chain.sv
module fpid_rule_chain
  import fpid_pkg::*;
(
  input  logic [1:0]        el,
  input  logic              el2_enabled,
  input  logic              el2_is_64,
  input  logic              el2_host,
  input  logic              el3_present,
  input  logic              el3_is_64,
  input  logic              ns_flag,
  input  logic              ns_cp10_en,
  input  logic [1:0]        cp10_access,
  input  logic              el2_fp_trap,
  input  logic              el3_fp_trap,
  input  logic              host_fp_en_lo,
  input  logic              hyp_cp10_trap,
  input  logic              id_trap,
  input  logic              dbg_undef_early,
  input  logic              dbg_undef_late,
  output fpid_outcome_e     outcome,
  output logic [CODE_W-1:0] code
);
  // Named condition wires, one per rule of the chain
  logic el2_a64, el2_a32, el3_a64, el3_a32, in_host;
  logic ns_block, cp_off, early_undef, host_fp_off, hyp_cond;
  logic el1_tfp2, el3_final;

  assign el2_a64     = el2_enabled & el2_is_64;
  assign el2_a32     = el2_enabled & ~el2_is_64;
  assign el3_a64     = el3_present & el3_is_64;
  assign el3_a32     = el3_present & ~el3_is_64;
  assign in_host     = el2_a64 & el2_host;
  assign ns_block    = el3_a32 & ns_flag & ~ns_cp10_en;
  assign cp_off      = (cp10_access == 2'b00);
  assign early_undef = el3_a64 & el3_fp_trap & dbg_undef_early;
  assign host_fp_off = in_host & ~host_fp_en_lo;
  assign hyp_cond    = el2_a32 & (ns_block | hyp_cp10_trap);
  assign el1_tfp2    = el2_a64 & ~el2_host & el2_fp_trap;
  assign el3_final   = el3_a64 & el3_fp_trap;

  always_comb begin
    outcome = OUT_DONE;
    code    = '0;
    unique case (el)
      2'd0: outcome = OUT_UNDEF;
      2'd1: begin
        if (early_undef)                 outcome = OUT_UNDEF;
        else if (ns_block || cp_off)     outcome = OUT_UNDEF;
        else if (el1_tfp2 || host_fp_off) begin
          outcome = OUT_TRAP2; code = CODE_FP_USE;
        end else if (hyp_cond) begin
          outcome = OUT_HYP;   code = CODE_ID_GRP;
        end else if (el2_a64 && id_trap) begin
          outcome = OUT_TRAP2; code = CODE_ID_GRP;
        end else if (el2_a32 && id_trap) begin
          outcome = OUT_HYP;   code = CODE_ID_GRP;
        end else if (el3_final) begin
          if (dbg_undef_late) outcome = OUT_UNDEF;
          else begin outcome = OUT_TRAP3; code = CODE_FP_USE; end
        end
      end
      2'd2: begin
        if (early_undef)                 outcome = OUT_UNDEF;
        else if (host_fp_off) begin
          outcome = OUT_TRAP2; code = CODE_FP_USE;
        end else if (hyp_cond) begin
          outcome = OUT_HYP;   code = CODE_HYP_L2;
        end else if (el3_final) begin
          if (dbg_undef_late) outcome = OUT_UNDEF;
          else begin outcome = OUT_TRAP3; code = CODE_FP_USE; end
        end
      end
      default: begin
        if (cp_off) outcome = OUT_UNDEF;
      end
    endcase
  end
endmodule

// File: rtl/fpid_access_gate.sv
module fpid_access_gate
  import fpid_pkg::*;
#(
  parameter logic [7:0] IMPLEMENTER = 8'h5A,
  parameter logic [6:0] SUBARCH     = 7'h03,
  parameter logic [7:0] PART        = 8'h30,
  parameter logic [3:0] VARIANT     = 4'h1,
  parameter logic [3:0] REVISION    = 4'h2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic        req_write,
  input  logic [1:0]  req_el,
  input  logic        el2_enabled,
  input  logic        el2_is_64,
  input  logic        el2_host,
  input  logic        el3_present,
  input  logic        el3_is_64,
  input  logic        ns_flag,
  input  logic        ns_cp10_en,
  input  logic [1:0]  cp10_access,
  input  logic        el2_fp_trap,
  input  logic        el3_fp_trap,
  input  logic        host_fp_en_lo,
  input  logic        hyp_cp10_trap,
  input  logic        id_trap,
  input  logic        dbg_undef_early,
  input  logic        dbg_undef_late,
  output logic        rsp_valid,
  output logic        rsp_done,
  output logic        rsp_undef,
  output logic        rsp_trap_el2,
  output logic        rsp_trap_el3,
  output logic        rsp_trap_hyp,
  output logic [5:0]  rsp_code,
  output logic [31:0] rsp_rdata
);
  fpid_outcome_e     dec_outcome;
  logic [CODE_W-1:0] dec_code;
  logic [WORD_W-1:0] id_word;
  logic              dec_read_ok;
  logic [1:0]        q_el;
  logic              q_write;

  fpid_id_word #(
    .IMPLEMENTER(IMPLEMENTER), .SUBARCH(SUBARCH), .PART(PART),
    .VARIANT(VARIANT), .REVISION(REVISION)
  ) u_word (
    .id_word(id_word)
  );

  fpid_rule_chain u_chain (
    .el(req_el), .el2_enabled(el2_enabled), .el2_is_64(el2_is_64),
    .el2_host(el2_host), .el3_present(el3_present), .el3_is_64(el3_is_64),
    .ns_flag(ns_flag), .ns_cp10_en(ns_cp10_en), .cp10_access(cp10_access),
    .el2_fp_trap(el2_fp_trap), .el3_fp_trap(el3_fp_trap),
    .host_fp_en_lo(host_fp_en_lo), .hyp_cp10_trap(hyp_cp10_trap),
    .id_trap(id_trap), .dbg_undef_early(dbg_undef_early),
    .dbg_undef_late(dbg_undef_late), .outcome(dec_outcome), .code(dec_code)
  );

  assign dec_read_ok = (dec_outcome == OUT_DONE) && !req_write;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid    <= 1'b0;
      rsp_done     <= 1'b0;
      rsp_undef    <= 1'b0;
      rsp_trap_el2 <= 1'b0;
      rsp_trap_el3 <= 1'b0;
      rsp_trap_hyp <= 1'b0;
      rsp_code     <= '0;
      rsp_rdata    <= '0;
      q_el         <= '0;
      q_write      <= 1'b0;
    end else begin
      rsp_valid    <= req_valid;
      rsp_done     <= req_valid && (dec_outcome == OUT_DONE);
      rsp_undef    <= req_valid && (dec_outcome == OUT_UNDEF);
      rsp_trap_el2 <= req_valid && (dec_outcome == OUT_TRAP2);
      rsp_trap_el3 <= req_valid && (dec_outcome == OUT_TRAP3);
      rsp_trap_hyp <= req_valid && (dec_outcome == OUT_HYP);
      rsp_code     <= req_valid ? dec_code : '0;
      rsp_rdata    <= (req_valid && dec_read_ok) ? id_word : '0;
      q_el         <= req_valid ? req_el : 2'd0;
      q_write      <= req_valid && req_write;
    end
  end

  assert_rsp_follows_req_R1: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
  assert_no_spurious_rsp_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);
  assert_one_outcome_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $onehot({rsp_done, rsp_undef, rsp_trap_el2, rsp_trap_el3, rsp_trap_hyp}));
  assert_quiet_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_valid |-> ({rsp_done, rsp_undef, rsp_trap_el2, rsp_trap_el3, rsp_trap_hyp} == 5'b0
                    && rsp_code == '0 && rsp_rdata == '0));
  assert_el0_undef_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && q_el == 2'd0) |-> rsp_undef);
  assert_hyp_code_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_trap_hyp |-> ((q_el == 2'd2 && rsp_code == 6'h00) ||
                      (q_el == 2'd1 && rsp_code == 6'h08)));
  assert_el3_no_trap_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && q_el == 2'd3) |-> !(rsp_trap_el2 || rsp_trap_el3 || rsp_trap_hyp));
  assert_rdata_gate_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_done) |-> (rsp_rdata == '0));
  assert_write_no_data_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && q_write) |-> (rsp_rdata == '0));
endmodule

// File: tb/sim_fpid_access_gate.sv
`timescale 1ns/1ps
module sim_fpid_access_gate;
  localparam logic [31:0] WORD = 32'hC3045E79;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 0, req_write = 0;
  logic [1:0] req_el = 0, cp10_access = 0;
  logic el2_enabled = 0, el2_is_64 = 0, el2_host = 0, el3_present = 0, el3_is_64 = 0;
  logic ns_flag = 0, ns_cp10_en = 0, el2_fp_trap = 0, el3_fp_trap = 0, host_fp_en_lo = 0;
  logic hyp_cp10_trap = 0, id_trap = 0, dbg_undef_early = 0, dbg_undef_late = 0;
  logic rsp_valid, rsp_done, rsp_undef, rsp_trap_el2, rsp_trap_el3, rsp_trap_hyp;
  logic [5:0] rsp_code;
  logic [31:0] rsp_rdata;
  int checks = 0, fails = 0;

  always #4 clk = ~clk;

  fpid_access_gate #(.IMPLEMENTER(8'hC3), .SUBARCH(7'h04), .PART(8'h5E),
                     .VARIANT(4'h7), .REVISION(4'h9)) u0 (.*);

  task automatic check(input logic ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      if (fails < 30) $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // kind: 0 done, 1 undef, 2 trap EL2, 3 trap EL3, 4 hyp
  function automatic logic [8:0] model(input logic [16:0] v, output string tag);
    logic [1:0] el; logic e2, e264, hm, e3, e364, ns, nse, off, t2, t3, fe, tcp, tid, pe, pl;
    logic host, nsb, a32;
    el = v[1:0]; e2 = v[2]; e264 = v[3]; hm = v[4]; e3 = v[5]; e364 = v[6];
    ns = v[7]; nse = v[8]; off = v[9]; t2 = v[10]; t3 = v[11]; fe = v[12];
    tcp = v[13]; tid = v[14]; pe = v[15]; pl = v[16];
    host = e2 & e264 & hm;
    nsb  = e3 & !e364 & ns & !nse;
    a32  = e2 & !e264;
    tag = "R12";
    if (el == 0) begin tag = "R3"; return {3'd1, 6'h00}; end
    if (el == 3) begin tag = "R10"; return off ? {3'd1, 6'h00} : {3'd0, 6'h00}; end
    if (e3 && e364 && t3 && pe) begin tag = "R4"; return {3'd1, 6'h00}; end
    if (el == 1 && (nsb || off)) begin tag = "R5"; return {3'd1, 6'h00}; end
    if ((el == 1 && e2 && e264 && !hm && t2) || (host && !fe)) begin
      tag = "R6"; return {3'd2, 6'h07};
    end
    if (a32 && (nsb || tcp)) begin
      tag = "R7"; return {3'd4, (el == 1) ? 6'h08 : 6'h00};
    end
    if (el == 1 && tid && e2) begin
      tag = "R8"; return e264 ? {3'd2, 6'h08} : {3'd4, 6'h08};
    end
    if (e3 && e364 && t3) begin
      tag = "R9"; return pl ? {3'd1, 6'h00} : {3'd3, 6'h07};
    end
    return {3'd0, 6'h00};
  endfunction

  task automatic apply(input logic [16:0] v);
    req_valid = 1; req_write = ^v; req_el = v[1:0];
    el2_enabled = v[2]; el2_is_64 = v[3]; el2_host = v[4];
    el3_present = v[5]; el3_is_64 = v[6]; ns_flag = v[7]; ns_cp10_en = v[8];
    cp10_access = v[9] ? 2'b00 : ((v[10] ^ v[16]) ? 2'b01 : 2'b11);
    el2_fp_trap = v[10]; el3_fp_trap = v[11]; host_fp_en_lo = v[12];
    hyp_cp10_trap = v[13]; id_trap = v[14]; dbg_undef_early = v[15]; dbg_undef_late = v[16];
  endtask

  function automatic logic [2:0] seen_kind();
    if (rsp_done) return 3'd0;
    if (rsp_undef) return 3'd1;
    if (rsp_trap_el2) return 3'd2;
    if (rsp_trap_el3) return 3'd3;
    return 3'd4;
  endfunction

  task automatic check_rsp(input logic [16:0] v);
    string tag; logic [8:0] e; logic [31:0] ed; int n;
    e = model(v, tag);
    ed = (e[8:6] == 3'd0 && !(^v)) ? WORD : 32'h0;
    n = rsp_done + rsp_undef + rsp_trap_el2 + rsp_trap_el3 + rsp_trap_hyp;
    check(rsp_valid && n == 1, "R2 single outcome", {rsp_valid, n[7:0]}, 64'h101);
    check(seen_kind() == e[8:6] && rsp_code == e[5:0], tag,
          {seen_kind(), rsp_code}, e);
    check(rsp_rdata == ed, "R11 read data", rsp_rdata, ed);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=hung expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(!rsp_valid && !rsp_done && rsp_rdata == 0 && rsp_code == 0, "R1 reset state",
          {rsp_valid, rsp_rdata}, 0);
    rst_n = 1;
    @(negedge clk);
    check(!rsp_valid, "R1 idle no response", rsp_valid, 0);
    // Directed read at EL3 with access enabled
    apply(17'h00203); req_write = 0; cp10_access = 2'b11;
    @(negedge clk); req_valid = 0;
    check(rsp_valid && rsp_done, "R10 EL3 read completes", rsp_done, 1);
    check(rsp_rdata == WORD, "R11 word layout", rsp_rdata, WORD);
    check(rsp_rdata[23] == 0 && (rsp_rdata[22:16] == 7'h03 || rsp_rdata[22:16] == 7'h04),
          "R13 subarch field", rsp_rdata[23:16], 8'h04);
    @(negedge clk);
    check(!rsp_valid && !rsp_done, "R1 single cycle pulse", rsp_valid, 0);
    // Directed write, then read again
    apply(17'h00203); req_write = 1; cp10_access = 2'b11;
    @(negedge clk); req_write = 0;
    check(rsp_done && rsp_rdata == 0, "R12 write completes silently", rsp_rdata, 0);
    @(negedge clk); req_valid = 0;
    check(rsp_done && rsp_rdata == WORD, "R12 read after write", rsp_rdata, WORD);
    @(negedge clk);
    check(!rsp_valid && rsp_code == 0, "R2 quiet between responses", rsp_code, 0);
    // Full sweep, one request per cycle, pipelined checking
    for (int v = 0; v < 131072; v++) begin
      apply(17'(v));
      @(negedge clk);
      check_rsp(17'(v));
    end
    req_valid = 0;
    @(negedge clk);
    check(!rsp_valid, "R1 no response after last request", rsp_valid, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule